// File: doc/BRIEF.md
# Random Memory Traffic Checker

This block drives a stream of pseudo-random single-beat reads and writes into a memory port under test and checks the returned read data. It keeps a shadow copy of three small address windows. Two windows are cacheable and one is uncacheable. Each window is preloaded with a fixed byte pattern. Each write updates the shadow when the request issues. Each read captures its expected bytes from the shadow at the same moment.

Every request draws its parameters from a seedable 32-bit LFSR:
- read or write, set by a programmable read percentage;
- cacheable or uncacheable, set by a programmable uncacheable percentage;
- the target window;
- the offset inside the window;
- an access size of 1, 2, 4 or 8 bytes.

Only one request is outstanding at a time.

A stall input holds back new requests. A no-response counter flags a hung target. A programmable read budget ends the run. The first mismatching read is latched so the failing address, the received data and the expected data can be read out.

Top module: `mem_traffic_checker`

## Requirements
- R1: After reset, error_o, deadlock_o and done_o are 0, both counters are 0, and no request is presented in the first cycle after reset. That cycle loads the seed.
- R2: Let u be bits [15:0] of the first draw modulo 100. If u is below pct_unc_i, the request sets req_uncache_o and targets base 0x800000. Otherwise bit 31 of the second draw selects base 0x100000 (1) or 0x400000 (0). The offset is the low log2(REGION_BYTES) bits of the second draw.
- R3: req_size_o carries the size exponent, taken from bits [30:29] of the second draw, so the size is 1 << req_size_o bytes. The address is aligned to that size by clearing its low offset bits.
- R4: Let v be bits [31:16] of the first draw modulo 100. If v is below pct_read_i, the request is a read (req_write_o = 0). Otherwise it is a write. Write data is the low size bytes of {fourth draw, third draw}, and the upper bytes are zero.
- R5: The LFSR steps as s' = (s >> 1) ^ (s[0] ? 0x80200003 : 0). It loads seed_i in the first cycle after reset, and a zero seed is replaced by 1. The four draws are the four successive states after the current one. Each issued request advances the state by four steps.
- R6: While blocked_i is 1, no request is presented and the LFSR does not advance.
- R7: After a request issues, no new request is presented until rsp_valid_i arrives. A rsp_valid_i arriving with nothing outstanding is ignored.
- R8: The windows preload to 0x01 (0x100000), 0x02 (0x400000) and 0x03 (0x800000) in every byte. Writes update the shadow at issue. A read response matching the shadow bytes captured at issue raises no error.
- R9: A read response whose low size bytes differ from the expected bytes sets error_o, which is sticky. The first failure latches its address, its received data and its expected data, each masked to the access size.
- R10: rd_count_o counts completed reads and wr_count_o counts completed writes.
- R11: When max_reads_i is nonzero and rd_count_o equals it, done_o is 1 and no further request is presented. When max_reads_i is 0, the block runs without end.
- R12: A no-response counter clears on every response and otherwise increments each cycle while not done. deadlock_o rises, and stays high, at the edge where the counter reaches WDOG_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seed_i | input | 32 | LFSR seed, loaded after reset |
| pct_read_i | input | 7 | Read percentage threshold |
| pct_unc_i | input | 7 | Uncacheable percentage threshold |
| max_reads_i | input | CNT_W | Read budget, 0 for unlimited |
| blocked_i | input | 1 | Target stall, no issue while high |
| req_valid_o | output | 1 | Request presented this cycle |
| req_write_o | output | 1 | 1 for write, 0 for read |
| req_uncache_o | output | 1 | Uncacheable access |
| req_addr_o | output | ADDR_W | Byte address, size aligned |
| req_size_o | output | 2 | Size exponent |
| req_wdata_o | output | 64 | Write data, low bytes valid |
| rsp_valid_i | input | 1 | Response completes the outstanding request |
| rsp_data_i | input | 64 | Read data, low bytes valid |
| error_o | output | 1 | Sticky read mismatch |
| deadlock_o | output | 1 | Sticky no-response timeout |
| done_o | output | 1 | Read budget reached |
| rd_count_o | output | CNT_W | Completed reads |
| wr_count_o | output | CNT_W | Completed writes |
| err_addr_o | output | ADDR_W | Address of first mismatch |
| err_got_o | output | 64 | Data received on first mismatch |
| err_exp_o | output | 64 | Data expected on first mismatch |

## Verification
The hardest case to reach is a write followed by a read of an overlapping address range with a different size. This is the case that proves the shadow tracks partial overwrites. The stimulus uses 32-byte windows, so random offsets collide often, and runs several thousand mixed accesses with random stalls and latencies. Error capture cannot occur with an honest target, so the bench memory model corrupts one bit of the first read it answers in one phase. Deadlock needs the stall held for the full timeout with no traffic.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_WAIT} mtc_state_e;

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? LFSR_TAPS : 32'h0);
  endfunction

  // window 0/1 cacheable, 2 uncacheable
  function automatic logic [31:0] window_base(input logic [1:0] w);
    case (w)
      2'd0:    return 32'h0010_0000;
      2'd1:    return 32'h0040_0000;
      default: return 32'h0080_0000;
    endcase
  endfunction

  function automatic logic [63:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00ff;
      2'd1:    return 64'h0000_0000_0000_ffff;
      2'd2:    return 64'h0000_0000_ffff_ffff;
      default: return 64'hffff_ffff_ffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/mtc_rand.sv
module mtc_rand #(
  parameter int OFF_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [31:0]      seed_i,
  input  logic             adv_i,
  input  logic [6:0]       pct_read_i,
  input  logic [6:0]       pct_unc_i,
  output logic             is_read_o,
  output logic             is_unc_o,
  output logic [1:0]       window_o,
  output logic [1:0]       size_o,
  output logic [OFF_W-1:0] off_o,
  output logic [63:0]      wdata_o
);
  import mtc_pkg::*;

  logic [31:0] state_q, r0, r1, r2, r3;
  logic [15:0] roll_unc, roll_rd;
  logic [OFF_W-1:0] align_m;
  logic unused_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= 32'h1;
    else if (load_i) state_q <= (seed_i == 32'h0) ? 32'h1 : seed_i;
    else if (adv_i)  state_q <= r3;
  end

  always_comb begin
    r0 = lfsr_next(state_q);
    r1 = lfsr_next(r0);
    r2 = lfsr_next(r1);
    r3 = lfsr_next(r2);
    roll_unc = r0[15:0] % 16'd100;
    roll_rd  = r0[31:16] % 16'd100;
    is_unc_o  = roll_unc < {9'd0, pct_unc_i};
    is_read_o = roll_rd < {9'd0, pct_read_i};
    window_o  = is_unc_o ? 2'd2 : (r1[31] ? 2'd0 : 2'd1);
    size_o    = r1[30:29];
    align_m   = OFF_W'((32'd1 << size_o) - 32'd1);
    off_o     = r1[OFF_W-1:0] & ~align_m;
    wdata_o   = {r3, r2} & size_mask(size_o);
  end

  assign unused_bits = ^r1;

  a_r5_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 32'h0);
endmodule

// File: rtl/mtc_shadow.sv
module mtc_shadow #(
  parameter int REGION_BYTES = 32,
  localparam int OFF_W = $clog2(REGION_BYTES),
  localparam int DEPTH = 3 * REGION_BYTES,
  localparam int IDX_W = $clog2(DEPTH + 8)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       window_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic             we_i,
  input  logic [63:0]      wdata_i,
  output logic [63:0]      rdata_o
);
  logic [7:0] mem_q [DEPTH];
  logic [IDX_W-1:0] base_idx;

  assign base_idx = IDX_W'(window_i) * IDX_W'(REGION_BYTES) + IDX_W'(off_i);

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < 8; k++)
      if (k < (1 << size_i)) rdata_o[k*8 +: 8] = mem_q[base_idx + IDX_W'(k)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'(i / REGION_BYTES + 1);
    end else if (we_i) begin
      for (int k = 0; k < 8; k++)
        if (k < (1 << size_i)) mem_q[base_idx + IDX_W'(k)] <= wdata_i[k*8 +: 8];
    end
  end
endmodule

// File: rtl/mtc_watchdog.sv
module mtc_watchdog #(
  parameter int LIMIT = 5000,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic deadlock_o
);
  logic [W-1:0] cnt_q;
  logic dl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dl_q  <= 1'b0;
    end else begin
      if (kick_i) cnt_q <= '0;
      else if (run_i && cnt_q != W'(LIMIT)) cnt_q <= cnt_q + W'(1);
      if (!kick_i && run_i && cnt_q == W'(LIMIT - 1)) dl_q <= 1'b1;
    end
  end

  assign deadlock_o = dl_q;

  a_r12_deadlock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deadlock_o |=> deadlock_o);
  a_r12_kick_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> cnt_q == '0);
endmodule

// File: rtl/mem_traffic_checker.sv
module mem_traffic_checker #(
  parameter int ADDR_W       = 24,
  parameter int REGION_BYTES = 32,
  parameter int CNT_W        = 16,
  parameter int WDOG_LIMIT   = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       seed_i,
  input  logic [6:0]        pct_read_i,
  input  logic [6:0]        pct_unc_i,
  input  logic [CNT_W-1:0]  max_reads_i,
  input  logic              blocked_i,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic              req_uncache_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [1:0]        req_size_o,
  output logic [63:0]       req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [63:0]       rsp_data_i,
  output logic              error_o,
  output logic              deadlock_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  rd_count_o,
  output logic [CNT_W-1:0]  wr_count_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [63:0]       err_got_o,
  output logic [63:0]       err_exp_o
);
  import mtc_pkg::*;
  localparam int OFF_W = $clog2(REGION_BYTES);
  localparam logic [ADDR_W-1:0] W0 = ADDR_W'(32'h0010_0000);
  localparam logic [ADDR_W-1:0] W1 = ADDR_W'(32'h0040_0000);
  localparam logic [ADDR_W-1:0] W2 = ADDR_W'(32'h0080_0000);
  localparam logic [ADDR_W-1:0] WSZ = ADDR_W'(REGION_BYTES);

  mtc_state_e st_q;
  logic is_read, is_unc, issue, rsp_fire, mismatch;
  logic [1:0] window, size;
  logic [OFF_W-1:0] off;
  logic [63:0] wdata, shadow_rd, rsp_masked;
  logic p_write_q;
  logic [1:0] p_size_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [63:0] p_exp_q;
  logic [CNT_W-1:0] rd_cnt_q, wr_cnt_q;
  logic err_q;
  logic [ADDR_W-1:0] err_addr_q;
  logic [63:0] err_got_q, err_exp_q;

  assign done_o   = (max_reads_i != '0) && (rd_cnt_q == max_reads_i);
  assign issue    = (st_q == ST_IDLE) && !blocked_i && !done_o;
  assign rsp_fire = (st_q == ST_WAIT) && rsp_valid_i;
  assign rsp_masked = rsp_data_i & size_mask(p_size_q);
  assign mismatch = rsp_fire && !p_write_q && (rsp_masked != p_exp_q);

  mtc_rand #(.OFF_W(OFF_W)) u_rand (
    .clk_i, .rst_ni,
    .load_i     (st_q == ST_INIT),
    .seed_i,
    .adv_i      (issue),
    .pct_read_i, .pct_unc_i,
    .is_read_o  (is_read),
    .is_unc_o   (is_unc),
    .window_o   (window),
    .size_o     (size),
    .off_o      (off),
    .wdata_o    (wdata)
  );

  mtc_shadow #(.REGION_BYTES(REGION_BYTES)) u_shadow (
    .clk_i, .rst_ni,
    .window_i (window),
    .off_i    (off),
    .size_i   (size),
    .we_i     (issue && !is_read),
    .wdata_i  (wdata),
    .rdata_o  (shadow_rd)
  );

  mtc_watchdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk_i, .rst_ni,
    .run_i      (!done_o),
    .kick_i     (rsp_fire),
    .deadlock_o (deadlock_o)
  );

  assign req_valid_o   = issue;
  assign req_write_o   = !is_read;
  assign req_uncache_o = is_unc;
  assign req_addr_o    = ADDR_W'(window_base(window)) + ADDR_W'(off);
  assign req_size_o    = size;
  assign req_wdata_o   = is_read ? 64'h0 : wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_INIT;
      p_write_q <= 1'b0;
      p_size_q  <= '0;
      p_addr_q  <= '0;
      p_exp_q   <= '0;
      rd_cnt_q  <= '0;
      wr_cnt_q  <= '0;
    end else begin
      case (st_q)
        ST_INIT: st_q <= ST_IDLE;
        ST_IDLE: if (issue) begin
          st_q      <= ST_WAIT;
          p_write_q <= !is_read;
          p_size_q  <= size;
          p_addr_q  <= req_addr_o;
          p_exp_q   <= shadow_rd;
        end
        default: if (rsp_valid_i) begin
          st_q <= ST_IDLE;
          if (p_write_q) wr_cnt_q <= wr_cnt_q + CNT_W'(1);
          else           rd_cnt_q <= rd_cnt_q + CNT_W'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q      <= 1'b0;
      err_addr_q <= '0;
      err_got_q  <= '0;
      err_exp_q  <= '0;
    end else if (mismatch && !err_q) begin
      err_q      <= 1'b1;
      err_addr_q <= p_addr_q;
      err_got_q  <= rsp_masked;
      err_exp_q  <= p_exp_q;
    end
  end

  assign error_o    = err_q;
  assign err_addr_o = err_addr_q;
  assign err_got_o  = err_got_q;
  assign err_exp_o  = err_exp_q;
  assign rd_count_o = rd_cnt_q;
  assign wr_count_o = wr_cnt_q;

  a_r7_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);
  a_r3_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ((req_addr_o & ADDR_W'((32'd1 << req_size_o) - 32'd1)) == '0));
  a_r2_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_uncache_o ? (req_addr_o >= W2 && req_addr_o < W2 + WSZ)
                     : ((req_addr_o >= W0 && req_addr_o < W0 + WSZ) ||
                        (req_addr_o >= W1 && req_addr_o < W1 + WSZ))));
  a_r9_error_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> (error_o && $stable(err_addr_o) && $stable(err_got_o)));
  a_r11_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_valid_o);
  a_r10_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_count_o - $past(rd_count_o)) <= CNT_W'(1));
  a_r6_blocked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && blocked_i) |=> st_q == ST_IDLE);
endmodule

// File: tb/sim_mem_traffic_checker.sv
`timescale 1ns/100ps
module sim_mem_traffic_checker;
  localparam int AW = 24, RB = 32, CW = 16, LIMIT = 5000;

  logic clk_i = 0, rst_ni = 0;
  logic [31:0] seed_i = 0;
  logic [6:0] pct_read_i = 0, pct_unc_i = 0;
  logic [CW-1:0] max_reads_i = 0;
  logic blocked_i = 0, rsp_valid_i = 0;
  logic [63:0] rsp_data_i = 0;
  logic req_valid_o, req_write_o, req_uncache_o, error_o, deadlock_o, done_o;
  logic [AW-1:0] req_addr_o, err_addr_o;
  logic [1:0] req_size_o;
  logic [63:0] req_wdata_o, err_got_o, err_exp_o;
  logic [CW-1:0] rd_count_o, wr_count_o;

  always #2.5 clk_i = ~clk_i;

  mem_traffic_checker u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_lfsr;
  logic [7:0] m_mem [3*RB];
  bit outst, p_wr, inj_done;
  int lat;
  logic [63:0] p_exp, e_got, e_exp;
  logic [AW-1:0] p_addr, e_addr;
  int m_rd, m_wr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic logic [63:0] bmask(input int nb);
    return (nb == 8) ? '1 : ((64'h1 << (nb * 8)) - 1);
  endfunction

  task automatic do_reset(input logic [31:0] sd, input int prd, input int pun, input int mx);
    rst_ni = 0; blocked_i = 0; rsp_valid_i = 0; rsp_data_i = 0;
    seed_i = sd; pct_read_i = 7'(prd); pct_unc_i = 7'(pun); max_reads_i = CW'(mx);
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    m_lfsr = (sd == 0) ? 32'h1 : sd;
    for (int i = 0; i < 3*RB; i++) m_mem[i] = 8'(i / RB + 1);
    outst = 0; inj_done = 0; m_rd = 0; m_wr = 0; lat = 0;
    #1;
    chk(req_valid_o == 0, "R1", "no request in seed cycle", req_valid_o, 0);
    chk(!error_o && !deadlock_o && !done_o, "R1", "status clear",
        {error_o, deadlock_o, done_o}, 0);
    chk(rd_count_o == 0 && wr_count_o == 0, "R1", "counters clear",
        {rd_count_o, wr_count_o}, 0);
    @(negedge clk_i);
  endtask

  task automatic run(input int n, input int blk_pct, input bit inj);
    logic [31:0] r0, r1, r2, r3;
    bit unc, rd, exp_v;
    int wnd, sz, nb, off, idx;
    logic [AW-1:0] ea;
    logic [63:0] wd, rdv;
    string tag;
    for (int c = 0; c < n; c++) begin
      blocked_i = ($urandom % 100) < blk_pct;
      rsp_valid_i = 0; rsp_data_i = 64'h0;
      if (outst) begin
        if (lat == 0) begin
          rsp_valid_i = 1;
          rsp_data_i = p_exp;
          if (inj && !p_wr && !inj_done) begin
            rsp_data_i = p_exp ^ 64'h1;
            inj_done = 1; e_addr = p_addr; e_got = p_exp ^ 64'h1; e_exp = p_exp;
          end
        end else lat--;
      end
      #1;
      exp_v = !outst && !blocked_i && !(max_reads_i != 0 && m_rd == max_reads_i);
      tag = outst ? "R7" : (blocked_i ? "R6" : (exp_v ? "R5" : "R11"));
      chk(req_valid_o == exp_v, tag, "req_valid", req_valid_o, exp_v);
      if (req_valid_o && exp_v) begin
        r0 = step(m_lfsr); r1 = step(r0); r2 = step(r1); r3 = step(r2);
        unc = (r0[15:0] % 100) < pct_unc_i;
        rd  = (r0[31:16] % 100) < pct_read_i;
        sz = int'(r1[30:29]); nb = 1 << sz;
        off = int'(r1[4:0]) & ~(nb - 1);
        wnd = unc ? 2 : (r1[31] ? 0 : 1);
        ea = AW'((wnd == 0) ? 32'h100000 : (wnd == 1) ? 32'h400000 : 32'h800000) + AW'(off);
        chk(req_uncache_o == unc && req_addr_o == ea, "R2", "window/address",
            {req_uncache_o, req_addr_o}, {unc, ea});
        chk(req_size_o == 2'(sz), "R3", "size", req_size_o, 2'(sz));
        chk(req_write_o == !rd, "R4", "direction", req_write_o, !rd);
        idx = wnd * RB + off;
        if (rd) begin
          rdv = 0;
          for (int k = 0; k < nb; k++) rdv[k*8 +: 8] = m_mem[idx + k];
          p_exp = rdv;
        end else begin
          wd = {r3, r2} & bmask(nb);
          chk(req_wdata_o == wd, "R4", "write data", req_wdata_o, wd);
          for (int k = 0; k < nb; k++) m_mem[idx + k] = wd[k*8 +: 8];
          p_exp = 0;
        end
        p_wr = !rd; p_addr = ea; outst = 1; lat = $urandom % 4;
        m_lfsr = r3;
      end
      if (rsp_valid_i) begin
        outst = 0;
        if (p_wr) m_wr++; else m_rd++;
      end
      @(negedge clk_i);
    end
    rsp_valid_i = 0; blocked_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed);
    // Phase A: mixed traffic, unlimited budget, spurious responses first
    do_reset(32'h1234_5678, 65, 10, 0);
    blocked_i = 1; rsp_valid_i = 1; rsp_data_i = 64'hdead_beef_0bad_f00d;
    repeat (3) @(negedge clk_i);
    rsp_valid_i = 0;
    #1;
    chk(rd_count_o == 0 && wr_count_o == 0 && !error_o, "R7", "idle response ignored",
        {rd_count_o, wr_count_o, error_o}, 0);
    @(negedge clk_i);
    run(6000, 30, 0);
    chk(!error_o, "R8", "no mismatch on honest memory", error_o, 0);
    chk(rd_count_o == CW'(m_rd), "R10", "read count", rd_count_o, m_rd);
    chk(wr_count_o == CW'(m_wr), "R10", "write count", wr_count_o, m_wr);
    chk(!deadlock_o, "R12", "responses keep watchdog clear", deadlock_o, 0);
    chk(!done_o, "R11", "zero budget never done", done_o, 0);

    // Phase B: all cacheable reads, zero seed, budget of 40
    do_reset(32'h0, 100, 0, 40);
    run(600, 10, 0);
    chk(done_o, "R11", "done at budget", done_o, 1);
    chk(rd_count_o == 40 && wr_count_o == 0, "R10", "budget counts",
        {rd_count_o, wr_count_o}, {16'd40, 16'd0});
    chk(!error_o, "R8", "preload pattern read back", error_o, 0);

    // Phase C: all uncacheable writes
    do_reset(32'hCAFE_F00D, 0, 100, 0);
    run(500, 20, 0);
    chk(rd_count_o == 0 && wr_count_o == CW'(m_wr) && m_wr > 0, "R10", "write-only counts",
        {rd_count_o, wr_count_o}, {16'd0, 16'(m_wr)});

    // Phase D: one corrupted read response
    do_reset(32'hA5A5_0F0F, 50, 30, 0);
    run(400, 10, 1);
    chk(inj_done, "R9", "corruption injected", inj_done, 1);
    chk(error_o, "R9", "error flag", error_o, 1);
    chk(err_addr_o == e_addr, "R9", "error address", err_addr_o, e_addr);
    chk(err_got_o == e_got, "R9", "error received data", err_got_o, e_got);
    chk(err_exp_o == e_exp, "R9", "error expected data", err_exp_o, e_exp);

    // Phase E: target stalled forever
    do_reset(32'h0000_0042, 65, 10, 0);
    blocked_i = 1;
    repeat (LIMIT - 2) @(posedge clk_i);
    @(negedge clk_i);
    chk(!deadlock_o, "R12", "no deadlock one cycle early", deadlock_o, 0);
    chk(!req_valid_o, "R6", "stalled target sees no request", req_valid_o, 0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(deadlock_o, "R12", "deadlock at limit", deadlock_o, 1);
    repeat (5) @(negedge clk_i);
    chk(deadlock_o, "R12", "deadlock sticky", deadlock_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule